// File: doc/BRIEF.md
# ASID-Tagged Multi-Way Translation Buffer

This block is a small set-associative translation buffer for 32-bit virtual addresses. It is organised as several ways that are searched in parallel. A group of small ways uses fixed 4 KB pages, and each small way selects its entry from the address bits just above the page offset. One large way has a page size set by a two-bit code. Every entry stores a masked virtual page tag, a masked physical page base, an 8-bit address-space identifier and a 4-bit attribute. An identifier of zero marks an entry as empty.

A 32-bit ring identifier register holds one identifier byte per privilege ring. When a lookup hits, the ring of the hit entry is the position of the byte that equals the entry's identifier. The lookup result is registered and appears one cycle after the request. The result is either a translation, a miss, a multi-hit, or a privilege violation. It comes with a cause code that tells instruction-side from data-side requests, and with a probe word that names the hitting way. When a write changes the ring identifier register, the block emits a one-cycle flush pulse for any cached translation state that lies downstream.

Top module: `asid_tlb`

## Requirements
- R1: After reset the ring identifier register `ringAsid` reads 0x04030201. A write through `ringWr` stores `{ringWrData[31:8], 8'h01}`, so bits [7:0] always read 0x01.
- R2: `flushAll` is high for exactly the one cycle that follows a ring identifier write whose stored value differs from the previous value. A write that leaves the value unchanged gives no pulse.
- R3: The ring of a hit entry is the lowest byte index i (0 to 3) for which `ringAsid[8i+7:8i]` equals the entry identifier. If no byte matches, the ring is 3.
- R4: An entry hits only when its identifier is non-zero and its stored tag equals `lkVaddr` ANDed with that way's page mask. Reset clears every identifier, so every lookup misses until entries are written.
- R5: `rsCause` = {side, status}. Side is 1 for data and 0 for instruction (taken from `lkData`). Status is 0 for translation, 1 for miss (no way hits), 2 for multi-hit (two or more ways hit) and 3 for privilege violation. Multi-hit is checked before privilege.
- R6: The small ways 0 to NUM_SMALL_WAYS-1 use the page mask 0xFFFFF000 and the entry index `vaddr[12 +: SMALL_IDX_W]`.
- R7: The large way (index NUM_SMALL_WAYS) has the page mask 0xFFF00000 << (2*pageCode). Its 2-bit entry index is taken from `vaddr` starting at bit 20 + 2*pageCode.
- R8: A single hit whose ring is numerically below `lkRing` gives status 3 and no translation.
- R9: On a translation, `rsProbe` = `{lkVaddr[31:12], 12'h0}` ORed with the way number and with 0x10 for data-side or 0x08 for instruction-side requests.
- R10: On a translation, `rsPaddr` = stored physical base ORed with the `lkVaddr` bits outside the way's page mask. `rsWay`, `rsRing` and `rsAttr` give the hit way, its ring and its attribute.
- R11: `wrEn` writes tag = `wrVaddr` & mask, base = `wrPpn` & mask, identifier and attribute into way `wrWay`, at the index computed from `wrVaddr` with the current `pageCode`. The entry is visible to lookups from the next cycle on. A write to a way number of NUM_SMALL_WAYS+1 or more is ignored.
- R12: `rsValid` follows `lkValid` by one cycle. When the status is not 0, or `rsValid` is low, the outputs `rsPaddr`, `rsProbe`, `rsWay`, `rsRing` and `rsAttr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pageCode | input | 2 | Page size code of the large way |
| ringWr | input | 1 | Ring identifier register write strobe |
| ringWrData | input | 32 | Ring identifier write value |
| ringAsid | output | 32 | Current ring identifier register |
| flushAll | output | 1 | One-cycle pulse after the ring identifier value changes |
| wrEn | input | 1 | Entry write strobe |
| wrWay | input | 3 | Way to write |
| wrVaddr | input | 32 | Virtual address of the written entry (gives tag and index) |
| wrPpn | input | 32 | Physical base of the written entry |
| wrAsid | input | 8 | Identifier of the written entry (0 = empty) |
| wrAttr | input | 4 | Attribute of the written entry |
| lkValid | input | 1 | Lookup request |
| lkVaddr | input | 32 | Lookup virtual address |
| lkData | input | 1 | 1 = data-side, 0 = instruction-side |
| lkRing | input | 2 | Current privilege ring of the requester |
| rsValid | output | 1 | Result valid |
| rsCause | output | 3 | {side, status} |
| rsPaddr | output | 32 | Translated physical address |
| rsWay | output | 3 | Hit way |
| rsRing | output | 2 | Ring of the hit entry |
| rsAttr | output | 4 | Attribute of the hit entry |
| rsProbe | output | 32 | Probe word |

## Verification
The bench targets the case where two ways hold the same page, which must give a multi-hit and not a translation taken from the first way. It also covers empty entries whose tags still match, which a design that ignores the identifier would report as hits. It changes the large way's page code, so a design with a wrong shift would index the wrong entry or leave the wrong offset bits in the physical address. It rewrites the ring register so that an entry identifier matches no byte, or more than one byte, and a wrong priority shows up as a wrong ring or a spurious privilege violation. The flush pulse is checked for both a changed write and a repeated write. A design that pulses on every write fails the repeated case.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  localparam int WAY_W = 3;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_MISS  = 2'd1,
    ST_MULTI = 2'd2,
    ST_PRIV  = 2'd3
  } lkStatus_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic [WAY_W-1:0] way;
  } entryWrite_t;
endpackage

// File: rtl/asid_tlb_datapath.sv
module asid_tlb_datapath
  import asid_tlb_pkg::*;
#(
  parameter int NUM_SMALL_WAYS = 4,
  parameter int SMALL_IDX_W    = 2,
  localparam int NUM_WAYS      = NUM_SMALL_WAYS + 1,
  localparam int ENT           = 1 << SMALL_IDX_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  entryWrite_t         wrStb,
  input  logic [31:0]         wrVaddr,
  input  logic [31:0]         wrPpn,
  input  logic [7:0]          wrAsid,
  input  logic [3:0]          wrAttr,
  input  logic [1:0]          pageCode,
  input  logic [31:0]         lkVaddr,
  output logic [NUM_WAYS-1:0] hitVec,
  output logic [31:0]         selPpn,
  output logic [31:0]         selMask,
  output logic [7:0]          selAsid,
  output logic [3:0]          selAttr,
  output logic [WAY_W-1:0]    selWay
);
  logic [31:0] wayPpn  [NUM_WAYS];
  logic [31:0] wayMask [NUM_WAYS];
  logic [7:0]  wayAsid [NUM_WAYS];
  logic [3:0]  wayAttr [NUM_WAYS];

  logic [31:0] largeMask;
  logic [31:0] lkShift, wrShift;
  assign largeMask = 32'hFFF0_0000 << {pageCode, 1'b0};
  assign lkShift   = lkVaddr >> (6'd20 + {3'd0, pageCode, 1'b0});
  assign wrShift   = wrVaddr >> (6'd20 + {3'd0, pageCode, 1'b0});

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [31:0]            vpnQ  [ENT];
    logic [31:0]            ppnQ  [ENT];
    logic [7:0]             asidQ [ENT];
    logic [3:0]             attrQ [ENT];
    logic [SMALL_IDX_W-1:0] lkIdx, wrIdx;
    logic [31:0]            mask;

    if (w < NUM_SMALL_WAYS) begin : g_small
      assign mask  = 32'hFFFF_F000;
      assign lkIdx = lkVaddr[12 +: SMALL_IDX_W];
      assign wrIdx = wrVaddr[12 +: SMALL_IDX_W];
    end else begin : g_large
      assign mask  = largeMask;
      assign lkIdx = SMALL_IDX_W'(lkShift[1:0]);
      assign wrIdx = SMALL_IDX_W'(wrShift[1:0]);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int e = 0; e < ENT; e++) begin
          vpnQ[e]  <= '0;
          ppnQ[e]  <= '0;
          asidQ[e] <= '0;
          attrQ[e] <= '0;
        end
      end else if (wrStb.load && wrStb.way == WAY_W'(w)) begin
        vpnQ[wrIdx]  <= wrVaddr & mask;
        ppnQ[wrIdx]  <= wrPpn & mask;
        asidQ[wrIdx] <= wrAsid;
        attrQ[wrIdx] <= wrAttr;
      end
    end

    assign hitVec[w]  = (asidQ[lkIdx] != 8'd0) && (vpnQ[lkIdx] == (lkVaddr & mask));
    assign wayPpn[w]  = ppnQ[lkIdx];
    assign wayAsid[w] = asidQ[lkIdx];
    assign wayAttr[w] = attrQ[lkIdx];
    assign wayMask[w] = mask;
  end

  // one-hot OR mux; value is meaningful only for a single hit
  always_comb begin
    selPpn  = '0;
    selMask = '0;
    selAsid = '0;
    selAttr = '0;
    selWay  = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (hitVec[w]) begin
        selPpn  = selPpn  | wayPpn[w];
        selMask = selMask | wayMask[w];
        selAsid = selAsid | wayAsid[w];
        selAttr = selAttr | wayAttr[w];
        selWay  = selWay  | WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/asid_tlb_ctrl.sv
module asid_tlb_ctrl
  import asid_tlb_pkg::*;
#(
  parameter int NUM_SMALL_WAYS = 4,
  localparam int NUM_WAYS      = NUM_SMALL_WAYS + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ringWr,
  input  logic [31:0]         ringWrData,
  output logic [31:0]         ringAsid,
  output logic                flushAll,
  input  logic                wrEn,
  input  logic [WAY_W-1:0]    wrWay,
  output entryWrite_t         wrStb,
  input  logic                lkValid,
  input  logic [31:0]         lkVaddr,
  input  logic                lkData,
  input  logic [1:0]          lkRing,
  input  logic [NUM_WAYS-1:0] hitVec,
  input  logic [31:0]         selPpn,
  input  logic [31:0]         selMask,
  input  logic [7:0]          selAsid,
  input  logic [3:0]          selAttr,
  input  logic [WAY_W-1:0]    selWay,
  output logic                rsValid,
  output logic [2:0]          rsCause,
  output logic [31:0]         rsPaddr,
  output logic [WAY_W-1:0]    rsWay,
  output logic [1:0]          rsRing,
  output logic [3:0]          rsAttr,
  output logic [31:0]         rsProbe
);
  logic [31:0] ringNext;
  logic [1:0]  hitRing;
  lkStatus_e   status;
  int          hitCount;

  assign wrStb.load = wrEn && (int'(wrWay) < NUM_WAYS);
  assign wrStb.way  = wrWay;
  assign ringNext   = {ringWrData[31:8], 8'h01};

  always_comb begin
    hitRing = 2'd3;
    for (int i = 3; i >= 0; i--) begin
      if (ringAsid[8*i +: 8] == selAsid) hitRing = 2'(i);
    end
  end

  always_comb begin
    hitCount = $countones(hitVec);
    if (hitCount == 0)       status = ST_MISS;
    else if (hitCount > 1)   status = ST_MULTI;
    else if (hitRing < lkRing) status = ST_PRIV;
    else                     status = ST_OK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ringAsid <= 32'h0403_0201;
      flushAll <= 1'b0;
    end else begin
      flushAll <= ringWr && (ringNext != ringAsid);
      if (ringWr) ringAsid <= ringNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rsValid <= 1'b0;
      rsCause <= '0;
      rsPaddr <= '0;
      rsWay   <= '0;
      rsRing  <= '0;
      rsAttr  <= '0;
      rsProbe <= '0;
    end else begin
      rsValid <= lkValid;
      rsCause <= lkValid ? {lkData, status} : 3'd0;
      if (lkValid && status == ST_OK) begin
        rsPaddr <= selPpn | (lkVaddr & ~selMask);
        rsWay   <= selWay;
        rsRing  <= hitRing;
        rsAttr  <= selAttr;
        rsProbe <= {lkVaddr[31:12], 12'h000} | 32'(selWay) | (lkData ? 32'h10 : 32'h08);
      end else begin
        rsPaddr <= '0;
        rsWay   <= '0;
        rsRing  <= '0;
        rsAttr  <= '0;
        rsProbe <= '0;
      end
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int NUM_SMALL_WAYS = 4,
  parameter int SMALL_IDX_W    = 2,
  localparam int NUM_WAYS      = NUM_SMALL_WAYS + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  pageCode,
  input  logic        ringWr,
  input  logic [31:0] ringWrData,
  output logic [31:0] ringAsid,
  output logic        flushAll,
  input  logic        wrEn,
  input  logic [2:0]  wrWay,
  input  logic [31:0] wrVaddr,
  input  logic [31:0] wrPpn,
  input  logic [7:0]  wrAsid,
  input  logic [3:0]  wrAttr,
  input  logic        lkValid,
  input  logic [31:0] lkVaddr,
  input  logic        lkData,
  input  logic [1:0]  lkRing,
  output logic        rsValid,
  output logic [2:0]  rsCause,
  output logic [31:0] rsPaddr,
  output logic [2:0]  rsWay,
  output logic [1:0]  rsRing,
  output logic [3:0]  rsAttr,
  output logic [31:0] rsProbe
);
  entryWrite_t         wrStb;
  logic [NUM_WAYS-1:0] hitVec;
  logic [31:0]         selPpn, selMask;
  logic [7:0]          selAsid;
  logic [3:0]          selAttr;
  logic [WAY_W-1:0]    selWay;

  asid_tlb_ctrl #(.NUM_SMALL_WAYS(NUM_SMALL_WAYS)) u_ctrl (
    .clk, .rstN, .ringWr, .ringWrData, .ringAsid, .flushAll,
    .wrEn, .wrWay, .wrStb,
    .lkValid, .lkVaddr, .lkData, .lkRing,
    .hitVec, .selPpn, .selMask, .selAsid, .selAttr, .selWay,
    .rsValid, .rsCause, .rsPaddr, .rsWay, .rsRing, .rsAttr, .rsProbe
  );

  asid_tlb_datapath #(.NUM_SMALL_WAYS(NUM_SMALL_WAYS), .SMALL_IDX_W(SMALL_IDX_W)) u_dp (
    .clk, .rstN, .wrStb, .wrVaddr, .wrPpn, .wrAsid, .wrAttr, .pageCode,
    .lkVaddr, .hitVec, .selPpn, .selMask, .selAsid, .selAttr, .selWay
  );
endmodule

// File: rtl/asid_tlb_checker.sv
module asid_tlb_checker (
  input logic        clk,
  input logic        rstN,
  input logic        ringWr,
  input logic [31:0] ringAsid,
  input logic        flushAll,
  input logic        lkValid,
  input logic [1:0]  lkRing,
  input logic        rsValid,
  input logic [2:0]  rsCause,
  input logic [31:0] rsPaddr,
  input logic [1:0]  rsRing,
  input logic [31:0] rsProbe
);
  // R1
  ring_low_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    ringAsid[7:0] == 8'h01);

  // R2
  flush_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |-> $past(ringWr));

  // R12
  result_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rsValid);

  // R12
  result_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !rsValid);

  // R8
  priv_ring_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> (rsCause[1:0] != 2'd0) || (rsRing >= $past(lkRing)));

  // R5
  multi_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rsValid && rsCause[1:0] == 2'd2) |-> (rsPaddr == 32'd0 && rsProbe == 32'd0));

  // R9
  probe_side_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rsValid && rsCause[1:0] == 2'd0) |-> (rsProbe[4:3] == (rsCause[2] ? 2'b10 : 2'b01)));
endmodule

bind asid_tlb asid_tlb_checker u_chk (.*);

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb;
  localparam int NSW = 4;
  localparam int NW  = NSW + 1;
  localparam int ENT = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  pageCode = '0;
  logic        ringWr = 1'b0;
  logic [31:0] ringWrData = '0;
  logic [31:0] ringAsid;
  logic        flushAll;
  logic        wrEn = 1'b0;
  logic [2:0]  wrWay = '0;
  logic [31:0] wrVaddr = '0, wrPpn = '0;
  logic [7:0]  wrAsid = '0;
  logic [3:0]  wrAttr = '0;
  logic        lkValid = 1'b0;
  logic [31:0] lkVaddr = '0;
  logic        lkData = 1'b0;
  logic [1:0]  lkRing = '0;
  logic        rsValid;
  logic [2:0]  rsCause;
  logic [31:0] rsPaddr;
  logic [2:0]  rsWay;
  logic [1:0]  rsRing;
  logic [3:0]  rsAttr;
  logic [31:0] rsProbe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  asid_tlb u_dut (.*);

  // reference model
  logic [31:0] mVpn  [NW][ENT];
  logic [31:0] mPpn  [NW][ENT];
  logic [7:0]  mAsid [NW][ENT];
  logic [3:0]  mAttr [NW][ENT];
  logic [31:0] mRing;

  function automatic logic [31:0] fMask(int w, logic [1:0] code);
    return (w < NSW) ? 32'hFFFF_F000 : (32'hFFF0_0000 << (2 * code));
  endfunction

  function automatic int fIdx(int w, logic [31:0] va, logic [1:0] code);
    return (w < NSW) ? int'(va[13:12]) : int'((va >> (20 + 2 * code)) & 32'h3);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doWrite(int w, logic [31:0] va, logic [31:0] pa, logic [7:0] id, logic [3:0] at);
    wrEn = 1'b1; wrWay = 3'(w); wrVaddr = va; wrPpn = pa; wrAsid = id; wrAttr = at;
    @(posedge clk);
    if (w < NW) begin
      int e;
      e = fIdx(w, va, pageCode);
      mVpn[w][e]  = va & fMask(w, pageCode);
      mPpn[w][e]  = pa & fMask(w, pageCode);
      mAsid[w][e] = id;
      mAttr[w][e] = at;
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRingWr(logic [31:0] v);
    logic [31:0] nv;
    nv = {v[31:8], 8'h01};
    ringWr = 1'b1; ringWrData = v;
    @(posedge clk);
    @(negedge clk);
    ringWr = 1'b0;
    chk("R2", {31'd0, flushAll}, {31'd0, nv != mRing}, "flush pulse");
    mRing = nv;
    chk("R1", ringAsid, mRing, "ring register");
  endtask

  task automatic doLookup(logic [31:0] va, logic dside, logic [1:0] cur, string tag);
    int hits, hw, he, ring;
    logic [1:0]  st;
    logic [31:0] ePa, ePr;
    logic [2:0]  eWay;
    logic [1:0]  eRing;
    logic [3:0]  eAt;
    hits = 0; hw = 0; he = 0;
    for (int w = 0; w < NW; w++) begin
      int e;
      e = fIdx(w, va, pageCode);
      if (mAsid[w][e] != 0 && mVpn[w][e] == (va & fMask(w, pageCode))) begin
        hits++; hw = w; he = e;
      end
    end
    ring = 3;
    for (int i = 3; i >= 0; i--)
      if (hits == 1 && mRing[8*i +: 8] == mAsid[hw][he]) ring = i;
    if (hits == 0)        st = 2'd1;
    else if (hits > 1)    st = 2'd2;
    else if (ring < cur)  st = 2'd3;
    else                  st = 2'd0;
    ePa = '0; ePr = '0; eWay = '0; eRing = '0; eAt = '0;
    if (st == 2'd0) begin
      ePa   = mPpn[hw][he] | (va & ~fMask(hw, pageCode));
      ePr   = {va[31:12], 12'h000} | 32'(hw) | (dside ? 32'h10 : 32'h08);
      eWay  = 3'(hw);
      eRing = 2'(ring);
      eAt   = mAttr[hw][he];
    end
    lkValid = 1'b1; lkVaddr = va; lkData = dside; lkRing = cur;
    @(posedge clk);
    @(negedge clk);
    lkValid = 1'b0;
    chk({tag, " R12"}, {31'd0, rsValid}, 32'd1, "valid");
    chk({tag, " R5"}, {29'd0, rsCause}, {29'd0, dside, st}, "cause");
    chk({tag, " R10"}, rsPaddr, ePa, "paddr");
    chk({tag, " R9"}, rsProbe, ePr, "probe");
    chk({tag, " R3"}, {27'd0, rsWay, rsRing}, {27'd0, eWay, eRing}, "way/ring");
    chk({tag, " R10"}, {28'd0, rsAttr}, {28'd0, eAt}, "attr");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned dummy;
    logic [31:0] bases [6];
    dummy = $urandom(32'd7781);
    bases = '{32'h1234_5000, 32'h5030_0000, 32'hA000_0000, 32'h0000_1000, 32'h60C0_0000, 32'hFFFF_C000};
    for (int w = 0; w < NW; w++)
      for (int e = 0; e < ENT; e++) begin
        mVpn[w][e] = '0; mPpn[w][e] = '0; mAsid[w][e] = '0; mAttr[w][e] = '0;
      end
    mRing = 32'h0403_0201;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    chk("R1", ringAsid, 32'h0403_0201, "reset ring register");
    chk("R12", {31'd0, rsValid}, 32'd0, "reset valid");
    doLookup(32'h0000_0000, 1'b0, 2'd0, "reset-miss R4");

    // basic hit on small way
    doWrite(0, 32'h1234_5000, 32'hABCD_E000, 8'h01, 4'h5);
    doLookup(32'h1234_5678, 1'b1, 2'd0, "basic R6 R11");
    chk("R10", rsPaddr, 32'hABCD_E678, "literal paddr");
    chk("R9", rsProbe, 32'h1234_5010, "literal data probe");
    doLookup(32'h1234_5678, 1'b0, 2'd0, "iside R9");
    chk("R9", rsProbe, 32'h1234_5008, "literal inst probe");
    // empty entry with matching tag
    doWrite(2, 32'h3333_3000, 32'h1111_1000, 8'h00, 4'h1);
    doLookup(32'h3333_3004, 1'b1, 2'd0, "empty R4");
    // ignored out-of-range way
    doWrite(7, 32'h7777_7000, 32'h2222_2000, 8'h01, 4'h2);
    doLookup(32'h7777_7000, 1'b1, 2'd0, "badway R11");
    // multi-hit
    doWrite(1, 32'h1234_5000, 32'h9999_9000, 8'h02, 4'h3);
    doLookup(32'h1234_5678, 1'b1, 2'd0, "multi R5");
    doLookup(32'h1234_5678, 1'b0, 2'd0, "multi-i R5");
    // privilege
    doWrite(3, 32'h4444_4000, 32'h5555_5000, 8'h03, 4'h7);
    doLookup(32'h4444_4abc, 1'b1, 2'd3, "priv R8");
    doLookup(32'h4444_4abc, 1'b1, 2'd2, "priv-ok R8");
    // ring remap
    doRingWr(32'h0706_05FF);
    doLookup(32'h4444_4abc, 1'b1, 2'd3, "nomatch R3");
    doRingWr(32'h0706_0500);
    doWrite(3, 32'h4444_5000, 32'h5555_6000, 8'h06, 4'h8);
    doLookup(32'h4444_5000, 1'b0, 2'd3, "ring2 R3 R8");
    doRingWr(32'h0606_0600);
    doLookup(32'h4444_5000, 1'b0, 2'd0, "lowest R3");
    doRingWr(32'h0403_0200);
    // large way page codes
    for (int c = 0; c < 4; c++) begin
      pageCode = 2'(c);
      doWrite(4, 32'h6FF0_0000 >> 0, 32'h8765_4321, 8'h04, 4'(c));
      doLookup(32'h6FFF_FFF4, 1'b1, 2'd0, "large R7");
      doLookup(32'h6FF0_0010 ^ (32'h1 << (20 + 2 * c)), 1'b1, 2'd0, "large-idx R7");
    end

    // constrained random
    for (int n = 0; n < 1500; n++) begin
      int unsigned r;
      logic [31:0] va;
      r = $urandom % 100;
      va = bases[$urandom % 6] ^ ($urandom & 32'h0030_3FFF);
      if (r < 30) begin
        doWrite(int'($urandom % 6), va, $urandom, 8'($urandom % 6), 4'($urandom));
      end else if (r < 36) begin
        doRingWr({8'($urandom % 6), 8'($urandom % 6), 8'($urandom % 6), 8'($urandom)});
      end else if (r < 40) begin
        pageCode = 2'($urandom);
        @(negedge clk);
      end else begin
        doLookup(va, 1'($urandom), 2'($urandom), "random R4 R5");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule